// File: doc/BRIEF.md
# Multilevel Coding Bitstream Partitioner

This block sits in front of the per-level convolutional encoders of a multilevel coding chain. It takes a serial information stream one bit per cycle and deals the bits out to up to three coding levels. Each output bit carries a level tag. Each level first gets its quota from the strongly protected part of the frame, and then gets its quota from the weakly protected part. The per-level quotas are inputs. They are computed elsewhere from the code rates and are captured when a frame starts.

There are two mappings. In standard mapping, levels 0 up to the configured level count take part in both passes. In symmetric hierarchical mapping, the main stream is dealt only to levels 1 and 2. A second, separate stream, which is the most robust one, then fills level 0 with its whole length. The block signals the end of a frame with a one-cycle flag. Input offered while no frame is open is dropped and reported as an overrun.

Top module: `lvlsplit_top`

## Requirements
- R1: In standard mapping (`hierMode`=0), after `frameStart` the main-stream bits go first to level 0 for `hiCounts` of level 0, then to level 1, then to level 2. Only levels below `numLevels` (binary, 1 to 3) take part. `outLevel` carries the level number in binary.
- R2: When the first pass is complete, the following main-stream bits go to the same levels in the same ascending order. Each level receives its `loCounts` quota. The count for level p is at bits [p*CW +: CW] of each count bus.
- R3: Over one frame, each active level receives exactly the sum of its higher and lower quotas, and the bits keep their input order. Levels at or above `numLevels` receive nothing, whatever their counts are.
- R4: In hierarchical mapping (`hierMode`=1), the main stream goes only to levels 1 and 2, first in the higher pass and then in the lower pass. `numLevels` has no effect in this mode, and no main-stream bit is tagged level 0.
- R5: In hierarchical mapping, once the main stream is used up, the bits on `vspBit`/`vspValid` go to level 0, and their number is the level-0 lower quota. The level-0 higher quota is ignored.
- R6: A quota of zero is skipped with no dead cycle. When input is offered on every cycle, the output bits of one frame appear on consecutive cycles.
- R7: A bit taken on a clock edge appears on `outBit`/`outValid`/`outLevel` for the cycle that follows. A valid bit on the stream that is not being consumed at that point produces no output.
- R8: `frameDone` is high for one cycle, and that cycle is the one in which the frame's last output bit is presented. If every quota in use is zero, `frameDone` is high in the cycle after the `frameStart` edge and no bit is output.
- R9: The mode, level count and quotas are captured at `frameStart`. While a frame is open, a new `frameStart` or a change of the configuration inputs has no effect on routing.
- R10: When no frame is open, each cycle with `inValid` or `vspValid` high raises `overrun` for the next cycle. The bit is dropped and no output is produced.
- R11: Out of reset, `outValid`, `frameDone` and `overrun` are low. `outValid` stays low in every cycle for which no bit was taken, so gaps in the input pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Opens a frame and captures the configuration (only honoured when no frame is open) |
| hierMode | input | 1 | 0 = standard mapping, 1 = symmetric hierarchical mapping |
| numLevels | input | 2 | Level count for standard mapping (1 to 3) |
| hiCounts | input | 3*CW | Higher-protected quota per level, level p at [p*CW +: CW] |
| loCounts | input | 3*CW | Lower-protected quota per level; level 0 gives the robust-stream length in hierarchical mapping |
| inBit | input | 1 | Main-stream data bit |
| inValid | input | 1 | Main-stream bit valid |
| vspBit | input | 1 | Robust-stream data bit (hierarchical mapping) |
| vspValid | input | 1 | Robust-stream bit valid |
| outBit | output | 1 | Routed bit |
| outValid | output | 1 | Routed bit valid |
| outLevel | output | 2 | Destination level of the routed bit |
| frameDone | output | 1 | One-cycle end-of-frame flag |
| overrun | output | 1 | Input was offered while no frame was open |

## Verification
The bench uses quota sets that include zero counts in the middle of a pass. A partitioner that did not skip these would either put one stray bit on the empty level or leave a hole in an otherwise continuous output run. It also runs a standard frame with `numLevels`=2 and non-zero level-2 quotas, and a hierarchical frame with a non-zero level-0 higher quota and `numLevels`=1. A design that honoured those settings would put extra bits on the wrong level. In the hierarchical frame, the idle stream is held valid the whole time, so any leak from the robust stream into the main passes (or the reverse) shows up as a corrupted sequence. A restart in mid-frame with a different configuration, an all-zero frame, and input offered after the end of a frame cover the cases of reloading while busy, a missing end flag, and bits being accepted when they should be flagged as overrun.

// File: rtl/lvlsplit_pkg.sv
package lvlsplit_pkg;
  localparam int LVLS  = 3;            // coding levels
  localparam int SLOTS = 2 * LVLS + 1; // higher pass, lower pass, robust stream
  localparam int SW    = $clog2(SLOTS + 1);

  localparam logic [SW-1:0] NO_SLOT  = SW'(SLOTS);
  localparam logic [SW-1:0] VSP_SLOT = SW'(SLOTS - 1);
  localparam logic [SW-1:0] LO_BASE  = SW'(LVLS);

  // strobes from control to datapath
  typedef struct packed {
    logic          load;
    logic          take;
    logic          fromVsp;
    logic          clrCnt;
    logic          done;
    logic          overrun;
    logic [SW-1:0] slot;
  } stb_t;

  // lowest enabled slot at or above 'from', NO_SLOT when none
  function automatic logic [SW-1:0] nextSlot(input logic [SLOTS-1:0] mask,
                                             input logic [SW:0]      from);
    logic [SW-1:0] r;
    r = NO_SLOT;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) r = SW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/lvlsplit_ctrl.sv
module lvlsplit_ctrl
  import lvlsplit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             inValid,
  input  logic             vspValid,
  input  logic [SLOTS-1:0] maskNext,
  input  logic [SLOTS-1:0] mask,
  input  logic             lastBit,
  output stb_t             stb
);
  logic          active, activeN;
  logic [SW-1:0] curSlot, slotN;
  logic [SW-1:0] firstS, candS;

  always_comb begin
    firstS = nextSlot(maskNext, '0);
    candS  = nextSlot(mask, {1'b0, curSlot} + 1'b1);
  end

  always_comb begin
    stb         = '0;
    stb.slot    = curSlot;
    stb.fromVsp = (curSlot == VSP_SLOT);
    stb.take    = active && (stb.fromVsp ? vspValid : inValid);
    stb.overrun = !active && (inValid || vspValid);
    stb.load    = !active && frameStart;
    activeN     = active;
    slotN       = curSlot;
    if (stb.load) begin
      stb.clrCnt = 1'b1;
      slotN      = firstS;
      activeN    = (firstS != NO_SLOT);
      stb.done   = (firstS == NO_SLOT);
    end else if (stb.take && lastBit) begin
      stb.clrCnt = 1'b1;
      slotN      = candS;
      activeN    = (candS != NO_SLOT);
      stb.done   = (candS == NO_SLOT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curSlot <= NO_SLOT;
    end else begin
      active  <= activeN;
      curSlot <= slotN;
    end
  end

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    active && $past(active) |-> curSlot >= $past(curSlot)); // R1

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    active && frameStart && !lastBit |=> active && curSlot == $past(curSlot)); // R9

  AST_IDLE_HAS_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> stb.slot == NO_SLOT); // R8
endmodule

// File: rtl/lvlsplit_dp.sv
module lvlsplit_dp
  import lvlsplit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic              hierIn,
  input  logic [1:0]        numLvlIn,
  input  logic [LVLS*CW-1:0] hiIn,
  input  logic [LVLS*CW-1:0] loIn,
  input  logic              inBit,
  input  logic              vspBit,
  output logic [SLOTS-1:0]  maskNext,
  output logic [SLOTS-1:0]  mask,
  output logic              lastBit,
  output logic              outBit,
  output logic              outValid,
  output logic [1:0]        outLevel,
  output logic              frameDone,
  output logic              overrun
);
  logic [CW-1:0] hiR [LVLS];
  logic [CW-1:0] loR [LVLS];
  logic          hierR;
  logic [CW-1:0] bitCnt, curLen;
  logic [1:0]    lvlNow;
  logic [LVLS-1:0] hiOn, loOn;
  logic          vspOn;

  // slot enables for the incoming configuration
  for (genvar p = 0; p < LVLS; p++) begin : g_en
    localparam logic [1:0] LV = 2'(p);
    logic inUse;
    assign inUse   = hierIn ? (p != 0) : (LV < numLvlIn);
    assign hiOn[p] = inUse && (hiIn[p*CW +: CW] != '0);
    assign loOn[p] = inUse && (loIn[p*CW +: CW] != '0);
  end
  assign vspOn    = hierIn && (loIn[0 +: CW] != '0);
  assign maskNext = {vspOn, loOn, hiOn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask  <= '0;
      hierR <= 1'b0;
      for (int p = 0; p < LVLS; p++) begin
        hiR[p] <= '0;
        loR[p] <= '0;
      end
    end else if (stb.load) begin
      mask  <= maskNext;
      hierR <= hierIn;
      for (int p = 0; p < LVLS; p++) begin
        hiR[p] <= hiIn[p*CW +: CW];
        loR[p] <= loIn[p*CW +: CW];
      end
    end
  end

  // quota and level of the current slot
  always_comb begin
    curLen = '0;
    lvlNow = '0;
    if (stb.slot < LO_BASE) begin
      lvlNow = stb.slot[1:0];
      curLen = hiR[lvlNow];
    end else if (stb.slot < VSP_SLOT) begin
      lvlNow = 2'(stb.slot - LO_BASE);
      curLen = loR[lvlNow];
    end else if (stb.slot == VSP_SLOT) begin
      curLen = loR[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           bitCnt <= '0;
    else if (stb.clrCnt) bitCnt <= '0;
    else if (stb.take)   bitCnt <= bitCnt + 1'b1;
  end
  assign lastBit = (bitCnt == curLen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit    <= 1'b0;
      outValid  <= 1'b0;
      outLevel  <= '0;
      frameDone <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      outBit    <= stb.fromVsp ? vspBit : inBit;
      outValid  <= stb.take;
      outLevel  <= lvlNow;
      frameDone <= stb.done;
      overrun   <= stb.overrun;
    end
  end

  logic [SLOTS:0] maskExt;
  assign maskExt = {1'b0, mask};

  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> maskExt[stb.slot]); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |-> bitCnt < curLen); // R3

  AST_HIER_MAIN_OFF_L0: assert property (@(posedge clk) disable iff (!rstN)
    stb.take && hierR && !stb.fromVsp |-> lvlNow != 2'd0); // R4

  AST_OVERRUN_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !outValid); // R10
endmodule

// File: rtl/lvlsplit_top.sv
module lvlsplit_top
  import lvlsplit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               hierMode,
  input  logic [1:0]         numLevels,
  input  logic [LVLS*CW-1:0] hiCounts,
  input  logic [LVLS*CW-1:0] loCounts,
  input  logic               inBit,
  input  logic               inValid,
  input  logic               vspBit,
  input  logic               vspValid,
  output logic               outBit,
  output logic               outValid,
  output logic [1:0]         outLevel,
  output logic               frameDone,
  output logic               overrun
);
  stb_t             stb;
  logic [SLOTS-1:0] maskNext, mask;
  logic             lastBit;

  lvlsplit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .inValid(inValid), .vspValid(vspValid),
    .maskNext(maskNext), .mask(mask), .lastBit(lastBit), .stb(stb)
  );

  lvlsplit_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hierIn(hierMode), .numLvlIn(numLevels), .hiIn(hiCounts), .loIn(loCounts),
    .inBit(inBit), .vspBit(vspBit),
    .maskNext(maskNext), .mask(mask), .lastBit(lastBit),
    .outBit(outBit), .outValid(outValid), .outLevel(outLevel),
    .frameDone(frameDone), .overrun(overrun)
  );
endmodule

// File: tb/tb_lvlsplit_top.sv
`timescale 1ns/1ps
module tb_lvlsplit_top;
  localparam int CW = 16;

  logic clk = 0, rstN = 0, frameStart = 0, hierMode = 0;
  logic [1:0] numLevels = 0;
  logic [3*CW-1:0] hiCounts = '0, loCounts = '0;
  logic inBit = 0, inValid = 0, vspBit = 0, vspValid = 0;
  logic outBit, outValid, frameDone, overrun;
  logic [1:0] outLevel;

  lvlsplit_top #(.CW(CW)) dut (.*);

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  int recLvl[512], recBit[512], recCyc[512];
  int recN = 0, doneCnt = 0, doneCyc = 0, ovCnt = 0;
  int expLvl[512], expBit[512];
  int expN, expSpp, expVsp;
  int cfgHi[3], cfgLo[3];
  logic cfgHier;
  int cfgNl;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (outValid) begin
      recLvl[recN] = int'(outLevel);
      recBit[recN] = int'(outBit);
      recCyc[recN] = cyc;
      recN++;
    end
    if (frameDone) begin doneCnt++; doneCyc = cyc; end
    if (overrun) ovCnt++;
  end

  function automatic logic patBit(int i, int salt);
    return (((i * 13) + (salt * 7)) % 5) < 2;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic buildExp();
    int s = 0;
    expN = 0;
    for (int pass = 0; pass < 2; pass++)
      for (int p = 0; p < 3; p++)
        if (cfgHier ? (p != 0) : (p < cfgNl))
          for (int k = 0; k < (pass == 0 ? cfgHi[p] : cfgLo[p]); k++) begin
            expLvl[expN] = p; expBit[expN] = int'(patBit(s, 0)); s++; expN++;
          end
    expSpp = s;
    expVsp = cfgHier ? cfgLo[0] : 0;
    for (int k = 0; k < expVsp; k++) begin
      expLvl[expN] = 0; expBit[expN] = int'(patBit(k, 1)); expN++;
    end
  endtask

  task automatic startFrame(logic h, int nl, int h0, int h1, int h2, int l0, int l1, int l2);
    @(posedge clk); #1;
    recN = 0; doneCnt = 0; ovCnt = 0;
    cfgHier = h; cfgNl = nl;
    cfgHi[0] = h0; cfgHi[1] = h1; cfgHi[2] = h2;
    cfgLo[0] = l0; cfgLo[1] = l1; cfgLo[2] = l2;
    @(negedge clk);
    hierMode = h; numLevels = 2'(nl);
    hiCounts = {CW'(h2), CW'(h1), CW'(h0)};
    loCounts = {CW'(l2), CW'(l1), CW'(l0)};
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
    buildExp();
  endtask

  task automatic streamFrame(bit noise, bit gappy, int restartAt);
    for (int i = 0; i < expSpp; i++) begin
      inBit = patBit(i, 0); inValid = 1;
      vspValid = noise; vspBit = 1;
      if (i == restartAt) begin
        frameStart = 1; numLevels = 2'd1;
        hiCounts = {CW'(0), CW'(0), CW'(1)};
        loCounts = {CW'(0), CW'(0), CW'(1)};
      end
      @(negedge clk);
      frameStart = 0;
      if (gappy) begin inValid = 0; vspValid = 0; @(negedge clk); end
    end
    inValid = 0; vspValid = 0;
    for (int j = 0; j < expVsp; j++) begin
      vspBit = patBit(j, 1); vspValid = 1;
      inValid = noise; inBit = 1;
      @(negedge clk);
    end
    inValid = 0; vspValid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkFrame(string req, bit gapless);
    int bad = -1;
    check(recN == expN, req, "bit count", recN, expN);
    for (int i = 0; i < expN && i < recN; i++)
      if (bad < 0 && (recLvl[i] != expLvl[i] || recBit[i] != expBit[i])) bad = i;
    check(bad < 0, req, "level*2+bit at first mismatch",
          bad < 0 ? 0 : recLvl[bad] * 2 + recBit[bad],
          bad < 0 ? 0 : expLvl[bad] * 2 + expBit[bad]);
    if (gapless && recN > 0)
      check(recCyc[recN-1] - recCyc[0] == recN - 1, "R6", "output span cycles",
            recCyc[recN-1] - recCyc[0], recN - 1);
    check(doneCnt == 1, "R8", "frameDone pulses", doneCnt, 1);
    if (recN > 0)
      check(doneCyc == recCyc[recN-1], "R8", "frameDone cycle", doneCyc, recCyc[recN-1]);
  endtask

  // scenarios
  task automatic tReset();
    repeat (3) @(negedge clk);
    check(outValid == 0, "R11", "outValid in reset", int'(outValid), 0);
    check(frameDone == 0, "R11", "frameDone in reset", int'(frameDone), 0);
    check(overrun == 0, "R11", "overrun in reset", int'(overrun), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tStd3();  // R1 R2 R3
    startFrame(0, 3, 3, 2, 1, 4, 5, 6);
    streamFrame(0, 0, -1);
    checkFrame("R1/R2", 1);
  endtask

  task automatic tStd2();  // R3: level 2 quotas ignored
    startFrame(0, 2, 2, 3, 9, 1, 4, 9);
    streamFrame(0, 0, -1);
    checkFrame("R3", 1);
  endtask

  task automatic tEepZeros();  // R6: empty higher pass and a zero middle quota
    startFrame(0, 3, 0, 0, 0, 3, 0, 2);
    streamFrame(0, 0, -1);
    checkFrame("R6", 1);
  endtask

  task automatic tHier();  // R4 R5 R7: other stream held valid as noise
    startFrame(1, 1, 5, 2, 3, 4, 1, 2);
    streamFrame(1, 0, -1);
    checkFrame("R4/R5/R7", 1);
  endtask

  task automatic tGaps();  // R11: idle input cycles give idle output cycles
    startFrame(0, 2, 1, 2, 0, 2, 1, 0);
    streamFrame(0, 1, -1);
    checkFrame("R11", 0);
    if (recN > 1)
      check(recCyc[1] - recCyc[0] == 2, "R11", "spacing of gapped bits", recCyc[1] - recCyc[0], 2);
  endtask

  task automatic tRestart();  // R9
    startFrame(0, 2, 2, 2, 0, 2, 1, 0);
    streamFrame(0, 0, 2);
    checkFrame("R9", 1);
  endtask

  task automatic tAllZero();  // R8
    startFrame(0, 3, 0, 0, 0, 0, 0, 0);
    check(frameDone == 1, "R8", "frameDone after empty start", int'(frameDone), 1);
    repeat (3) @(negedge clk);
    check(recN == 0, "R8", "bits in empty frame", recN, 0);
    check(doneCnt == 1, "R8", "frameDone pulses", doneCnt, 1);
  endtask

  task automatic tOverrun();  // R10
    @(posedge clk); #1;
    recN = 0; ovCnt = 0;
    @(negedge clk);
    inValid = 1; inBit = 1;
    repeat (2) @(negedge clk);
    inValid = 0; vspValid = 1;
    @(negedge clk);
    vspValid = 0;
    repeat (3) @(negedge clk);
    check(ovCnt == 3, "R10", "overrun cycles", ovCnt, 3);
    check(recN == 0, "R10", "bits output while idle", recN, 0);
  endtask

  initial begin
    tReset();
    tStd3();
    tStd2();
    tEepZeros();
    tHier();
    tGaps();
    tRestart();
    tAllZero();
    tOverrun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule